// File: doc/BRIEF.md
# Dual-Bus Bidirectional Storage Register

This block is a small parallel register that sits between two shared bidirectional buses, called A and B. On a rising clock edge it can take in a word from bus A, from bus B, or from both buses at once, where each bit is the OR of the two buses. If neither bus is selected, the register keeps its contents. Each bus side has its own output-float control. When that control is low, the stored word is driven back onto that bus. When it is high, that side of the register is high impedance. Both sides may drive at the same moment.

An active-high clear empties the register at once, with no clock needed, and it overrides every other control. The float controls act only on the output drivers. They never change what is stored, so the register can hold its word while both sides float. Each side also has a drive-enable output, which shows when that side is actively driving its bus.

A side that is driving its bus and is also selected for loading samples its own driven word. For those bits the register keeps its value, ORed with the other bus when both buses are selected. Any bus that is selected for loading must be driven by some agent, either the register itself or an outside one.

Top module: `dual_bus_reg`

## Requirements
- R1: While `clr` is 1, the stored word is 0 at once, without waiting for a clock edge, whatever the other controls are.
- R2: The stored word changes only on a rising `clk` edge. A bus change between edges is not seen on a driving side before the next edge.
- R3: With `load_a_n`=0 and `load_b_n`=1, a rising edge stores the word present on `bus_a`.
- R4: With `load_a_n`=1 and `load_b_n`=0, a rising edge stores the word present on `bus_b`.
- R5: With `load_a_n`=0 and `load_b_n`=0, a rising edge stores `bus_a | bus_b`, so a 1 on either bus sets that bit.
- R6: With `load_a_n`=1 and `load_b_n`=1, the stored word is kept across edges, including while both sides float.
- R7: With `hiz_a`=0, `bus_a` carries the stored word and `drv_a_en` is 1. With `hiz_a`=1, side A does not drive and `drv_a_en` is 0.
- R8: With `hiz_b`=0, `bus_b` carries the stored word and `drv_b_en` is 1. With `hiz_b`=1, side B does not drive and `drv_b_en` is 0.
- R9: Changing `hiz_a` or `hiz_b` never alters the stored word.
- R10: A side that drives while it is selected for loading contributes the stored word itself. The result is the old word when loading only that side, and the old word ORed with the other bus when loading both.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Capture clock, rising edge |
| clr | input | 1 | Asynchronous clear, active high |
| load_a_n | input | 1 | Capture from bus A, active low |
| load_b_n | input | 1 | Capture from bus B, active low |
| hiz_a | input | 1 | Float side A when 1, drive when 0 |
| hiz_b | input | 1 | Float side B when 1, drive when 0 |
| bus_a | inout | WIDTH | Bidirectional bus A |
| bus_b | inout | WIDTH | Bidirectional bus B |
| drv_a_en | output | 1 | 1 while side A drives bus_a |
| drv_b_en | output | 1 | 1 while side B drives bus_b |

## Verification
A captured word appears on a driving side one edge after the load controls are set. The bench sets inputs on the falling edge and compares results 2 ns after the following rising edge. The drive-enable outputs and the float state follow `hiz_a` and `hiz_b` within the same cycle, without any register in between. Clear acts within a cycle, so it is checked 1 ns after `clr` rises, before any clock edge. The register contents are also sampled 1 ns after each input change, to confirm that nothing moves ahead of the edge.

// File: rtl/dbr_pkg.sv
`timescale 1ns/1ps
package dbr_pkg;

    typedef enum logic [1:0] {
        SRC_HOLD = 2'b00,
        SRC_A    = 2'b01,
        SRC_B    = 2'b10,
        SRC_BOTH = 2'b11
    } src_e;

    // active-low load strobes to a capture source
    function automatic src_e decode_src(input logic la_n, input logic lb_n);
        return src_e'({~lb_n, ~la_n});
    endfunction

endpackage

// File: rtl/dbr_capture_mux.sv
`timescale 1ns/1ps
module dbr_capture_mux #(
    parameter int WIDTH = 4
) (
    input  dbr_pkg::src_e     src,
    input  logic [WIDTH-1:0]  cur,
    input  logic [WIDTH-1:0]  from_a,
    input  logic [WIDTH-1:0]  from_b,
    output logic [WIDTH-1:0]  nxt
);
    import dbr_pkg::*;

    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        always_comb begin
            unique case (src)
                SRC_A:    nxt[i] = from_a[i];
                SRC_B:    nxt[i] = from_b[i];
                SRC_BOTH: nxt[i] = from_a[i] | from_b[i];
                default:  nxt[i] = cur[i];
            endcase
        end
    end

endmodule

// File: rtl/dbr_side_ctl.sv
`timescale 1ns/1ps
module dbr_side_ctl (
    input  logic hiz,
    output logic drv_en
);
    assign drv_en = ~hiz;
endmodule

// File: rtl/dual_bus_reg.sv
`timescale 1ns/1ps
module dual_bus_reg #(
    parameter int WIDTH = 4
) (
    input  logic             clk,
    input  logic             clr,
    input  logic             load_a_n,
    input  logic             load_b_n,
    input  logic             hiz_a,
    input  logic             hiz_b,
    inout  wire [WIDTH-1:0]  bus_a,
    inout  wire [WIDTH-1:0]  bus_b,
    output logic             drv_a_en,
    output logic             drv_b_en
);
    import dbr_pkg::*;

    typedef struct packed {
        logic [WIDTH-1:0] store;
    } state_t;

    state_t           state_d, state_q;
    src_e             src;
    logic [WIDTH-1:0] cap_word;

    assign src = decode_src(load_a_n, load_b_n);

    dbr_capture_mux #(.WIDTH(WIDTH)) u_mux (
        .src    (src),
        .cur    (state_q.store),
        .from_a (bus_a),
        .from_b (bus_b),
        .nxt    (cap_word)
    );

    dbr_side_ctl u_side_a (.hiz(hiz_a), .drv_en(drv_a_en));
    dbr_side_ctl u_side_b (.hiz(hiz_b), .drv_en(drv_b_en));

    always_comb begin
        state_d       = state_q;
        state_d.store = cap_word;
    end

    always_ff @(posedge clk or posedge clr) begin
        if (clr) state_q <= '0;
        else     state_q <= state_d;
    end

    assign bus_a = drv_a_en ? state_q.store : {WIDTH{1'bz}};
    assign bus_b = drv_b_en ? state_q.store : {WIDTH{1'bz}};

endmodule

// File: rtl/dual_bus_reg_chk.sv
`timescale 1ns/1ps
module dual_bus_reg_chk #(
    parameter int WIDTH = 4
) (
    input logic             clk,
    input logic             clr,
    input logic             load_a_n,
    input logic             load_b_n,
    input logic             drv_a_en,
    input logic             drv_b_en,
    input logic [WIDTH-1:0] bus_a,
    input logic [WIDTH-1:0] bus_b,
    input logic [WIDTH-1:0] store
);
    // R1
    clear_zero_chk: assert property (@(posedge clk) clr |-> (store == '0));
    // R6
    hold_stable_chk: assert property (@(posedge clk) disable iff (clr)
        (load_a_n && load_b_n) |=> $stable(store));
    // R3
    load_a_chk: assert property (@(posedge clk) disable iff (clr)
        (!load_a_n && load_b_n) |=> (store == $past(bus_a)));
    // R4
    load_b_chk: assert property (@(posedge clk) disable iff (clr)
        (load_a_n && !load_b_n) |=> (store == $past(bus_b)));
    // R5
    load_both_chk: assert property (@(posedge clk) disable iff (clr)
        (!load_a_n && !load_b_n) |=> (store == ($past(bus_a) | $past(bus_b))));
    // R7
    drive_a_chk: assert property (@(posedge clk) disable iff (clr)
        drv_a_en |-> (bus_a == store));
    // R8
    drive_b_chk: assert property (@(posedge clk) disable iff (clr)
        drv_b_en |-> (bus_b == store));
endmodule

bind dual_bus_reg dual_bus_reg_chk #(.WIDTH(WIDTH)) u_chk (
    .clk      (clk),
    .clr      (clr),
    .load_a_n (load_a_n),
    .load_b_n (load_b_n),
    .drv_a_en (drv_a_en),
    .drv_b_en (drv_b_en),
    .bus_a    (bus_a),
    .bus_b    (bus_b),
    .store    (state_q.store)
);

// File: tb/dual_bus_reg_tb.sv
`timescale 1ns/1ps
module dual_bus_reg_tb;
    localparam int W = 4;

    logic clk = 0;
    logic clr = 1, load_a_n = 1, load_b_n = 1, hiz_a = 1, hiz_b = 1;
    logic a_oe = 0, b_oe = 0;
    logic [W-1:0] a_val = '0, b_val = '0;
    wire  [W-1:0] bus_a, bus_b;
    logic drv_a_en, drv_b_en;

    int vectors = 0, fails = 0;
    logic [W-1:0] model = '0;
    bit done = 0;

    assign bus_a = a_oe ? a_val : {W{1'bz}};
    assign bus_b = b_oe ? b_val : {W{1'bz}};

    always #4 clk = ~clk;

    dual_bus_reg #(.WIDTH(W)) u_dut (
        .clk(clk), .clr(clr), .load_a_n(load_a_n), .load_b_n(load_b_n),
        .hiz_a(hiz_a), .hiz_b(hiz_b), .bus_a(bus_a), .bus_b(bus_b),
        .drv_a_en(drv_a_en), .drv_b_en(drv_b_en)
    );

    task automatic chk(input bit ok, input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
        vectors++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic check_sides(input string tag);
        chk(drv_a_en == !hiz_a, "R7 drive enable A", W'(drv_a_en), W'(!hiz_a));
        chk(drv_b_en == !hiz_b, "R8 drive enable B", W'(drv_b_en), W'(!hiz_b));
        if (!hiz_a) chk(bus_a == model, tag, bus_a, model);
        if (!hiz_b) chk(bus_b == model, tag, bus_b, model);
    endtask

    task automatic step(input logic c, input logic la, input logic lb,
                        input logic ha, input logic hb,
                        input logic aoe, input logic [W-1:0] av,
                        input logic boe, input logic [W-1:0] bv,
                        input string tag);
        logic [W-1:0] sa, sb, nxt;
        @(negedge clk);
        clr = c; load_a_n = la; load_b_n = lb; hiz_a = ha; hiz_b = hb;
        a_oe = aoe && ha; a_val = av;
        b_oe = boe && hb; b_val = bv;
        sa = a_oe ? av : (!ha ? model : '0);
        sb = b_oe ? bv : (!hb ? model : '0);
        if (c) nxt = '0;
        else if (!la && lb) nxt = sa;
        else if (la && !lb) nxt = sb;
        else if (!la && !lb) nxt = sa | sb;
        else nxt = model;
        #1;
        if (c) model = '0;
        else check_sides("R2 no change before edge");
        @(posedge clk);
        model = nxt;
        #2;
        check_sides(tag);
    endtask

    initial begin
        #(200000 * 8);
        if (!done) begin
            fails++;
            vectors++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

    initial begin
        // R1 reset state
        step(1, 0, 0, 0, 0, 0, '0, 0, '0, "R1 clear");
        // R3 load from A, observe on B
        step(0, 0, 1, 1, 0, 1, 4'h5, 0, '0, "R3 load A");
        // R4 load from B, observe on A
        step(0, 1, 0, 0, 1, 0, '0, 1, 4'hA, "R4 load B");
        // R5 load both while floating, then reveal
        step(0, 0, 0, 1, 1, 1, 4'h3, 1, 4'h8, "R5 load both");
        step(0, 1, 1, 0, 0, 0, '0, 0, '0, "R5 OR result");
        // R6 hold with both sides floating and buses busy
        step(0, 1, 1, 1, 1, 1, 4'hF, 1, 4'h0, "R6 hold float");
        step(0, 1, 1, 1, 1, 1, 4'h0, 1, 4'h6, "R6 hold float");
        step(0, 1, 1, 0, 0, 0, '0, 0, '0, "R6 hold reveal");
        // R9 toggle float controls, word unchanged
        step(0, 1, 1, 1, 0, 0, '0, 0, '0, "R9 float toggle");
        step(0, 1, 1, 0, 1, 0, '0, 0, '0, "R9 float toggle");
        step(0, 1, 1, 0, 0, 0, '0, 0, '0, "R9 float toggle");
        // R10 loading a driving side
        step(0, 0, 1, 0, 0, 0, '0, 0, '0, "R10 self load A");
        step(0, 0, 0, 0, 1, 0, '0, 1, 4'h4, "R10 self OR B");
        step(0, 1, 0, 1, 0, 1, 4'h1, 0, '0, "R10 self load B");
        // R1 asynchronous clear mid-cycle
        @(negedge clk);
        hiz_a = 0; hiz_b = 0; a_oe = 0; b_oe = 0; load_a_n = 1; load_b_n = 1;
        #1 clr = 1;
        #1 chk(bus_a == '0, "R1 async clear A", bus_a, '0);
        chk(bus_b == '0, "R1 async clear B", bus_b, '0);
        model = '0;
        step(1, 0, 0, 1, 1, 1, 4'hF, 1, 4'hF, "R1 clear priority");
        // random mix
        for (int k = 0; k < 400; k++) begin
            logic la, lb, ha, hb, c;
            string t;
            c  = ($urandom_range(0, 19) == 0);
            la = $urandom_range(0, 1); lb = $urandom_range(0, 1);
            ha = $urandom_range(0, 1); hb = $urandom_range(0, 1);
            if (c) t = "R1 random";
            else if ((!la && !ha) || (!lb && !hb)) t = "R10 random";
            else if (!la && lb) t = "R3 random";
            else if (la && !lb) t = "R4 random";
            else if (!la && !lb) t = "R5 random";
            else t = "R6 random";
            step(c, la, lb, ha, hb, 1'b1, W'($urandom), 1'b1, W'($urandom), t);
        end
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule